// File: doc/BRIEF.md
# Banked Burst Address Counter with Repeat

This block produces the address that one memory port uses in each clock cycle. At every rising edge it picks one of four actions. It can take an external address, step an internal counter by one, hold the counter, or jump back to the start address it loaded most recently. The address is 18 bits wide. The upper 6 bits are a bank number and the lower 12 bits are an offset within that bank. Stepping treats the two fields as one number, so the count runs from one bank into the next and wraps from the last bank back to the first.

All three controls are active low. They act on their own and do not depend on any chip enable or byte select. Every load through the address strobe also saves the loaded address as the repeat target. A flag shows whether such a target exists. The current bank number is also given as a separate output, so that logic outside the block can compare the banks that two ports are addressing.

Top module: `burst_addr_gen`

## Requirements
- R1: While `rst` is high at a rising edge, `cur_addr` becomes 0 and `rpt_valid` becomes 0. Both hold these values until the first edge after `rst` falls.
- R2: With `repeat_n` high and `load_n` low at an edge, `cur_addr` after the edge equals `ext_addr`, whatever the level of `count_n`.
- R3: With `repeat_n` and `load_n` high and `count_n` low at an edge, `cur_addr` after the edge is the previous `cur_addr` plus one, modulo 2^18.
- R4: With all three controls high at an edge, `cur_addr` keeps its value, and `ext_addr` has no effect on it.
- R5: Stepping from offset 0xFFF in bank b (bits 17:12 = b, bits 11:0 = 0xFFF) gives bank b+1 with offset 0x000.
- R6: Stepping from bank 63 offset 0xFFF (address 0x3FFFF) gives address 0x00000.
- R7: With `repeat_n` low and `rpt_valid` high at an edge, `cur_addr` after the edge equals the stored repeat address, whatever the levels of `load_n`, `count_n` and `ext_addr`.
- R8: Each load under R2 replaces the stored repeat address, so a later repeat returns the most recent load.
- R9: `rpt_valid` rises on the first load under R2 and then stays high until reset. A repeat request while `rpt_valid` is low leaves `cur_addr` unchanged, and it neither loads `ext_addr` nor sets `rpt_valid`, even with `load_n` low.
- R10: `cur_bank` always equals bits 17:12 of `cur_addr`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| ext_addr | input | 18 | External address: bank in bits 17:12, offset in bits 11:0 |
| load_n | input | 1 | Address strobe, active low: load `ext_addr` |
| count_n | input | 1 | Count enable, active low: step the counter |
| repeat_n | input | 1 | Repeat, active low: return to the last loaded address |
| cur_addr | output | 18 | Address used in the current cycle |
| cur_bank | output | 6 | Bank field of `cur_addr` |
| rpt_valid | output | 1 | High once the repeat register holds a loaded address |

## Verification
The bench goes to the edge of every one of the 64 banks and steps across it, ending with the wrap from the top address to zero. A counter whose carry stopped at the offset field would stay in the same bank, and one that saturated would stick at 0x3FFFF. The bench also asserts repeat at the same time as the strobe, both before and after any load. A design that ranked the strobe above repeat would take the external address, and one that used the repeat register while it was invalid would jump to zero or set the flag. A long pseudo-random run over all eight control combinations is compared cycle by cycle with an arithmetic model. This run catches load-while-counting cases and holds during which `ext_addr` keeps changing.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;

    localparam int BANK_W = 6;
    localparam int OFS_W  = 12;
    localparam int ADDR_W = BANK_W + OFS_W;

    typedef struct packed {
        logic [BANK_W-1:0] bank;
        logic [OFS_W-1:0]  ofs;
    } baddr_t;

    typedef enum logic [1:0] {
        ACT_HOLD   = 2'd0,
        ACT_LOAD   = 2'd1,
        ACT_STEP   = 2'd2,
        ACT_RETURN = 2'd3
    } act_e;

    // Advance one location; the offset carry ripples into the bank field,
    // and the bank field wraps modulo its own width.
    function automatic baddr_t bump(input baddr_t a);
        baddr_t r;
        if (a.ofs == {OFS_W{1'b1}}) begin
            r.ofs  = '0;
            r.bank = a.bank + BANK_W'(1);
        end else begin
            r.ofs  = a.ofs + OFS_W'(1);
            r.bank = a.bank;
        end
        return r;
    endfunction

endpackage

// File: rtl/ctr_act_decode.sv
module ctr_act_decode
    import burst_addr_pkg::*;
(
    input  logic load_n,
    input  logic count_n,
    input  logic repeat_n,
    input  logic target_ok,
    output act_e act
);
    // Priority: repeat, then strobe, then count enable.
    always_comb begin
        if (!repeat_n)
            act = target_ok ? ACT_RETURN : ACT_HOLD;
        else if (!load_n)
            act = ACT_LOAD;
        else if (!count_n)
            act = ACT_STEP;
        else
            act = ACT_HOLD;
    end
endmodule

// File: rtl/ctr_repeat_store.sv
module ctr_repeat_store
    import burst_addr_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  act_e   act,
    input  baddr_t load_addr,
    output baddr_t target,
    output logic   target_ok
);
    always_ff @(posedge clk) begin
        if (rst) begin
            target    <= '0;
            target_ok <= 1'b0;
        end else if (act == ACT_LOAD) begin
            target    <= load_addr;
            target_ok <= 1'b1;
        end
    end

    // R8
    target_update_chk: assert property (@(posedge clk) disable iff (rst)
        (act == ACT_LOAD) |=> (target == $past(load_addr)));

    // R9
    target_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        target_ok |=> target_ok);
endmodule

// File: rtl/ctr_addr_core.sv
module ctr_addr_core
    import burst_addr_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  act_e   act,
    input  baddr_t ext,
    input  baddr_t target,
    output baddr_t addr
);
    baddr_t nxt;

    always_comb begin
        unique case (act)
            ACT_LOAD:   nxt = ext;
            ACT_STEP:   nxt = bump(addr);
            ACT_RETURN: nxt = target;
            default:    nxt = addr;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) addr <= '0;
        else     addr <= nxt;
    end

    // R2
    load_take_chk: assert property (@(posedge clk) disable iff (rst)
        (act == ACT_LOAD) |=> (addr == $past(ext)));

    // R3
    step_plus_one_chk: assert property (@(posedge clk) disable iff (rst)
        (act == ACT_STEP) |=> (ADDR_W'(addr) == ADDR_W'($past(addr) + ADDR_W'(1))));

    // R4
    hold_still_chk: assert property (@(posedge clk) disable iff (rst)
        (act == ACT_HOLD) |=> $stable(addr));

    // R7
    return_target_chk: assert property (@(posedge clk) disable iff (rst)
        (act == ACT_RETURN) |=> (addr == $past(target)));
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import burst_addr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] ext_addr,
    input  logic              load_n,
    input  logic              count_n,
    input  logic              repeat_n,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [BANK_W-1:0] cur_bank,
    output logic              rpt_valid
);
    act_e   act;
    baddr_t ext_s;
    baddr_t target;
    baddr_t addr_s;

    assign ext_s = baddr_t'(ext_addr);

    ctr_act_decode u_decode (
        .load_n    (load_n),
        .count_n   (count_n),
        .repeat_n  (repeat_n),
        .target_ok (rpt_valid),
        .act       (act)
    );

    ctr_repeat_store u_store (
        .clk       (clk),
        .rst       (rst),
        .act       (act),
        .load_addr (ext_s),
        .target    (target),
        .target_ok (rpt_valid)
    );

    ctr_addr_core u_core (
        .clk    (clk),
        .rst    (rst),
        .act    (act),
        .ext    (ext_s),
        .target (target),
        .addr   (addr_s)
    );

    assign cur_addr = addr_s;
    assign cur_bank = addr_s.bank;

    // R9
    no_target_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!repeat_n && !rpt_valid) |=> ($stable(cur_addr) && !rpt_valid));

    // R7
    repeat_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (!repeat_n && rpt_valid && !load_n) |=> (cur_addr == $past(target)));

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (cur_addr == '0 && !rpt_valid));
endmodule

// File: tb/tb_burst_addr_gen.sv
`timescale 1ns/1ps
module tb_burst_addr_gen;
    localparam int AW = 18;
    localparam int OW = 12;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] ext_addr = '0;
    logic          load_n = 1'b1;
    logic          count_n = 1'b1;
    logic          repeat_n = 1'b1;
    logic [AW-1:0] cur_addr;
    logic [5:0]    cur_bank;
    logic          rpt_valid;

    int total = 0;
    int bad   = 0;

    logic [AW-1:0] m_addr = '0;
    logic [AW-1:0] m_rpt  = '0;
    logic          m_ok   = 1'b0;
    string         m_tag  = "R1";

    always #10 clk = ~clk;

    burst_addr_gen dut (
        .clk(clk), .rst(rst), .ext_addr(ext_addr), .load_n(load_n),
        .count_n(count_n), .repeat_n(repeat_n), .cur_addr(cur_addr),
        .cur_bank(cur_bank), .rpt_valid(rpt_valid)
    );

    task automatic check(input string tag, input logic [AW-1:0] got, input logic [AW-1:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic compare_all();
        check(m_tag, cur_addr, m_addr);
        check("R9 flag", AW'(rpt_valid), AW'(m_ok));
        check("R10", AW'(cur_bank), AW'(m_addr >> OW));
    endtask

    // Drive at the falling edge, let one rising edge act, compare at the next falling edge.
    task automatic step(input logic ld, input logic cn, input logic rp, input logic [AW-1:0] ea);
        load_n = ld; count_n = cn; repeat_n = rp; ext_addr = ea;
        @(posedge clk);
        if (!rp) begin
            if (m_ok) begin m_addr = m_rpt; m_tag = "R7"; end
            else m_tag = "R9";
        end else if (!ld) begin
            m_addr = ea; m_rpt = ea; m_ok = 1'b1; m_tag = "R2";
        end else if (!cn) begin
            m_addr = m_addr + AW'(1); m_tag = "R3";
        end else m_tag = "R4";
        @(negedge clk);
        compare_all();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [15:0] lfsr;
        repeat (3) @(negedge clk);
        m_tag = "R1";
        compare_all();
        rst = 1'b0;

        // R9: repeat before any load, alone and together with the strobe
        step(1, 1, 0, 18'h2ABCD);
        step(0, 0, 0, 18'h12345);
        // R2: load while the count enable is also low
        step(0, 0, 1, 18'h01234);
        for (int i = 0; i < 5; i++) step(1, 0, 1, 18'h3FFFF);
        // R4: hold with a moving external address
        for (int i = 0; i < 4; i++) step(1, 1, 1, AW'(i * 18'h0F0F1));
        // R7: repeat wins over the strobe and the count enable
        step(1, 1, 0, 18'h00000);
        step(0, 0, 0, 18'h3C3C3);
        // R8: the latest load is the target
        step(0, 1, 1, 18'h11111);
        step(0, 1, 1, 18'h22222);
        step(1, 0, 1, 18'h0);
        step(1, 1, 0, 18'h0);
        // R5 / R6: cross every bank boundary, including the top wrap
        for (int b = 0; b < 64; b++) begin
            step(0, 1, 1, {6'(b), 12'hFFE});
            step(1, 0, 1, 18'h0);
            step(1, 0, 1, 18'h0);
            check((b == 63) ? "R6" : "R5", cur_addr, AW'({6'(b + 1), 12'h000}));
        end
        // R1: reset returns to zero and clears the flag
        rst = 1'b1;
        @(posedge clk); @(negedge clk);
        m_addr = '0; m_ok = 1'b0; m_tag = "R1";
        compare_all();
        rst = 1'b0;
        // Mixed sweep across all control combinations
        lfsr = 16'hACE1;
        for (int i = 0; i < 3000; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(lfsr[0] | lfsr[5], lfsr[1], lfsr[2] | lfsr[3] | lfsr[4],
                 (lfsr[6]) ? {lfsr[11:6], 12'hFFF} : {lfsr[15:0], lfsr[7:6]});
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule